// File: doc/BRIEF.md
# Multi-Node Doorbell Interrupt Hub

The hub links a group of nodes that share a memory region and lets any node interrupt any other node by ringing a doorbell. Each node sees its own small register window. The window holds an interrupt enable (mask), an 8-bit message status, a write-only doorbell, a read-only own-ID register and a read-only vector of live nodes. A doorbell word names a destination node in its upper byte and carries a message byte in its lower byte. The hub copies the message byte into the destination's status register. That node's interrupt line stays high while its status is non-zero and its enable bit is set.

A destination code of 255 sends the message to every live node except the sender. A doorbell written by a node is held in that sender's pending slot for one cycle of dispatch. When several senders aim at the same node, the lowest-numbered sender goes first and each later message overwrites the status one cycle after the one before it. Reading a node's status returns the message and clears it, which acknowledges the interrupt.

Top module: `dbh_hub`

## Requirements
- R1: Reading byte offset 6 returns the accessing node's own index. Reading byte offset 8 returns the live-node input vector in the low bits, with zeros above it.
- R2: A write to byte offset 4 is a doorbell. Bits [15:8] give the destination index and bits [7:0] the message. If the destination is live, its status register (byte offset 2, low 8 bits) holds the message after the second rising edge that follows the write. A node may ring itself.
- R3: Bit 0 of byte offset 0 is the interrupt enable. It reads back in bit 0 and resets to 0. A node's interrupt output is high exactly when its status is non-zero and its enable bit is 1.
- R4: A status read returns the current message, and the status becomes zero at that clock edge. If a delivery reaches the same node at the same edge, the new message is kept.
- R5: A destination code of 255 delivers the message to every live node except the sender.
- R6: A doorbell whose destination is not live, or is at or above the node count and is not 255, changes no status register.
- R7: When more than one sender's pending message targets the same node in one cycle, the lowest sender index is delivered first. The next one overwrites the status one cycle later.
- R8: Writes to the status, own-index and live-list offsets change nothing that can be read back.
- R9: After reset every status is zero, every enable is zero and every interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| node_live | input | NODES | One bit per node, 1 when the node is live |
| node_wr | input | NODES | Per-node register write strobe |
| node_rd | input | NODES | Per-node register read strobe (clears status on offset 2) |
| node_addr | input | NODES*4 | Per-node byte offset, node i in bits [4i+3:4i] |
| node_wdata | input | NODES*16 | Per-node write data, node i in bits [16i+15:16i] |
| node_rdata | output | NODES*16 | Per-node read data for the current offset, combinational |
| node_irq | output | NODES | Per-node interrupt line |

## Verification
Fault in a pending slot or an arbitration grant: the wrong status value or a missing interrupt shows on the destination's read port exactly two edges after the doorbell write. A stuck or mis-cleared status shows as an interrupt line that disagrees with the bench's enable/status model on the next cycle, or as a non-zero value on a read that should return zero. Contention faults show as the wrong message order across two consecutive cycles at a single destination.

// File: rtl/dbh_pkg.sv
package dbh_pkg;
   localparam int REG_AW = 4;
   localparam int REG_DW = 16;
   localparam int MSG_W  = 8;

   // Byte offsets of the per-node register window
   localparam logic [REG_AW-1:0] OFF_ENABLE = 4'd0;
   localparam logic [REG_AW-1:0] OFF_STATUS = 4'd2;
   localparam logic [REG_AW-1:0] OFF_BELL   = 4'd4;
   localparam logic [REG_AW-1:0] OFF_SELF   = 4'd6;
   localparam logic [REG_AW-1:0] OFF_LIVE   = 4'd8;

   localparam logic [7:0] DEST_ALL = 8'hFF;

   typedef struct packed {
      logic [7:0]       dest;
      logic [MSG_W-1:0] msg;
   } bell_t;
endpackage

// File: rtl/dbh_sender.sv
module dbh_sender
   import dbh_pkg::*;
#(
   parameter int NODES = 8,
   parameter int ID    = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bell_we,
   input  bell_t            bell,
   input  logic [NODES-1:0] live,
   input  logic [NODES-1:0] served,
   output logic [NODES-1:0] tgt,
   output logic [MSG_W-1:0] msg
);
   localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1;

   logic [NODES-1:0] new_tgt;

   always_comb begin
      new_tgt = '0;
      if (bell.dest == DEST_ALL) begin
         new_tgt     = live;
         new_tgt[ID] = 1'b0;
      end else if (32'(bell.dest) < NODES) begin
         new_tgt[bell.dest[IDX_W-1:0]] = live[bell.dest[IDX_W-1:0]];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt <= '0;
         msg <= '0;
      end else if (bell_we) begin
         tgt <= new_tgt;
         msg <= bell.msg;
      end else begin
         tgt <= tgt & ~served;
      end
   end

   // R6: an out-of-range destination leaves nothing pending
   a_r6_drop_bad_dest: assert property (@(posedge clk) disable iff (!rst_n)
      bell_we && bell.dest != DEST_ALL && 32'(bell.dest) >= NODES |=> tgt == '0);

   // R5: a broadcast never targets its own sender
   a_r5_bcast_skips_self: assert property (@(posedge clk) disable iff (!rst_n)
      bell_we && bell.dest == DEST_ALL |=> !tgt[ID]);

   // R7: a served target is retired from the slot
   a_r7_served_retired: assert property (@(posedge clk) disable iff (!rst_n)
      !bell_we && served != '0 |=> (tgt & $past(served)) == '0);
endmodule

// File: rtl/dbh_arbiter.sv
module dbh_arbiter
   import dbh_pkg::*;
#(
   parameter int NODES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NODES-1:0] req,
   input  logic [MSG_W-1:0] msgs [NODES],
   output logic [NODES-1:0] grant,
   output logic             hit,
   output logic [MSG_W-1:0] msg
);
   // Isolate the lowest set request bit
   assign grant = req & (~req + NODES'(1));
   assign hit   = |req;

   always_comb begin
      msg = '0;
      for (int s = 0; s < NODES; s++) begin
         if (grant[s]) msg = msgs[s];
      end
   end

   a_r7_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   a_r7_grant_in_req: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0);

   a_r7_req_served: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> grant != '0);
endmodule

// File: rtl/dbh_node_regs.sv
module dbh_node_regs
   import dbh_pkg::*;
#(
   parameter int NODES     = 8,
   parameter int ID        = 0,
   parameter bit RD_CLEARS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [REG_AW-1:0] addr,
   input  logic [REG_DW-1:0] wdata,
   input  logic [NODES-1:0]  live,
   input  logic              dlv,
   input  logic [MSG_W-1:0]  dlv_msg,
   output logic [REG_DW-1:0] rdata,
   output logic              irq,
   output logic              bell_we,
   output bell_t             bell
);
   logic             en_q;
   logic [MSG_W-1:0] status_q;
   logic             clr;

   assign bell_we = wr && (addr == OFF_BELL);
   assign bell    = bell_t'(wdata);

   generate
      if (RD_CLEARS) begin : g_rd_clear
         assign clr = rd && (addr == OFF_STATUS);
      end else begin : g_sticky
         assign clr = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         status_q <= '0;
      end else begin
         if (wr && addr == OFF_ENABLE) en_q <= wdata[0];
         if (dlv)      status_q <= dlv_msg;
         else if (clr) status_q <= '0;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         OFF_ENABLE: rdata[0]       = en_q;
         OFF_STATUS: rdata[MSG_W-1:0] = status_q;
         OFF_SELF:   rdata          = REG_DW'(ID);
         OFF_LIVE:   rdata[NODES-1:0] = live;
         default:    rdata          = '0;
      endcase
   end

   assign irq = en_q && (status_q != '0);

   // R3: an enabled node sees its interrupt after a non-zero delivery
   a_r3_irq_on_delivery: assert property (@(posedge clk) disable iff (!rst_n)
      dlv && dlv_msg != '0 && en_q && !(wr && addr == OFF_ENABLE) |=> irq);

   // R4: delivery takes precedence over a clearing read
   a_r4_delivery_wins: assert property (@(posedge clk) disable iff (!rst_n)
      dlv |=> status_q == $past(dlv_msg));

   // R4: a read with no delivery empties the status
   a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      RD_CLEARS && rd && addr == OFF_STATUS && !dlv |=> status_q == '0);

   // R8: a write to the status offset has no effect
   a_r8_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      wr && addr == OFF_STATUS && !dlv && !rd |=> $stable(status_q));
endmodule

// File: rtl/dbh_hub.sv
module dbh_hub
   import dbh_pkg::*;
#(
   parameter int NODES     = 8,
   parameter bit RD_CLEARS = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NODES-1:0]         node_live,
   input  logic [NODES-1:0]         node_wr,
   input  logic [NODES-1:0]         node_rd,
   input  logic [NODES*REG_AW-1:0]  node_addr,
   input  logic [NODES*REG_DW-1:0]  node_wdata,
   output logic [NODES*REG_DW-1:0]  node_rdata,
   output logic [NODES-1:0]         node_irq
);
   generate
      if (NODES < 2 || NODES > REG_DW) begin : g_bad_nodes
         $error("dbh_hub: NODES must lie between 2 and the register width");
      end
   endgenerate

   logic             bell_we [NODES];
   bell_t            bell    [NODES];
   logic [NODES-1:0] tgt     [NODES];
   logic [MSG_W-1:0] smsg    [NODES];
   logic [NODES-1:0] req     [NODES];
   logic [NODES-1:0] grant   [NODES];
   logic [NODES-1:0] served  [NODES];
   logic             dlv     [NODES];
   logic [MSG_W-1:0] dlv_msg [NODES];

   // Transpose sender-major targets into destination-major requests
   always_comb begin
      for (int s = 0; s < NODES; s++) begin
         for (int d = 0; d < NODES; d++) begin
            req[d][s]    = tgt[s][d];
            served[s][d] = grant[d][s];
         end
      end
   end

   generate
      for (genvar i = 0; i < NODES; i++) begin : g_node
         dbh_node_regs #(.NODES(NODES), .ID(i), .RD_CLEARS(RD_CLEARS)) regs_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (node_wr[i]),
            .rd      (node_rd[i]),
            .addr    (node_addr[i*REG_AW +: REG_AW]),
            .wdata   (node_wdata[i*REG_DW +: REG_DW]),
            .live    (node_live),
            .dlv     (dlv[i]),
            .dlv_msg (dlv_msg[i]),
            .rdata   (node_rdata[i*REG_DW +: REG_DW]),
            .irq     (node_irq[i]),
            .bell_we (bell_we[i]),
            .bell    (bell[i])
         );

         dbh_sender #(.NODES(NODES), .ID(i)) send_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .bell_we (bell_we[i]),
            .bell    (bell[i]),
            .live    (node_live),
            .served  (served[i]),
            .tgt     (tgt[i]),
            .msg     (smsg[i])
         );

         dbh_arbiter #(.NODES(NODES)) arb_i (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req[i]),
            .msgs  (smsg),
            .grant (grant[i]),
            .hit   (dlv[i]),
            .msg   (dlv_msg[i])
         );
      end
   endgenerate

   // R9: interrupts are quiet on the first cycle after reset
   a_r9_quiet_after_reset: assert property (@(posedge clk)
      $past(!rst_n) |-> node_irq == '0);
endmodule

// File: tb/dbh_hub_tb_top.sv
module dbh_hub_tb_top;
   import dbh_pkg::*;
   localparam int N = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n;
   logic [N-1:0]      live, wr, rd, irq;
   logic [N*4-1:0]    addr;
   logic [N*16-1:0]   wdata, rdata;
   int checks = 0, fails = 0;
   logic [7:0] m_stat [N];
   logic       m_en   [N];

   dbh_hub #(.NODES(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .node_live(live), .node_wr(wr), .node_rd(rd),
      .node_addr(addr), .node_wdata(wdata), .node_rdata(rdata), .node_irq(irq));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk); #1;
   endtask

   task automatic wreg(input int n, input logic [3:0] a, input logic [15:0] d);
      wr[n] = 1'b1; addr[n*4 +: 4] = a; wdata[n*16 +: 16] = d;
      tick;
      wr[n] = 1'b0;
   endtask

   task automatic rreg(input int n, input logic [3:0] a, output logic [15:0] v);
      rd[n] = 1'b1; addr[n*4 +: 4] = a;
      #1 v = rdata[n*16 +: 16];
      tick;
      rd[n] = 1'b0;
   endtask

   task automatic peek(input int n, input logic [3:0] a, output logic [15:0] v);
      addr[n*4 +: 4] = a;
      #1 v = rdata[n*16 +: 16];
   endtask

   function automatic logic [N-1:0] targets(int s, logic [7:0] dest, logic [N-1:0] lv);
      logic [N-1:0] t = '0;
      if (dest == 8'hFF) begin t = lv; t[s] = 1'b0; end
      else if (dest < N) t[dest[2:0]] = lv[dest[2:0]];
      return t;
   endfunction

   function automatic logic [N-1:0] exp_irq();
      logic [N-1:0] e;
      for (int i = 0; i < N; i++) e[i] = m_en[i] && (m_stat[i] != 8'h00);
      return e;
   endfunction

   task automatic ring(input int s, input logic [7:0] dest, input logic [7:0] v);
      logic [N-1:0] t;
      t = targets(s, dest, live);
      wr[s] = 1'b1; addr[s*4 +: 4] = OFF_BELL; wdata[s*16 +: 16] = {dest, v};
      tick;
      wr[s] = 1'b0;
      tick;
      for (int i = 0; i < N; i++) if (t[i]) m_stat[i] = v;
   endtask

   task automatic set_en(input int n, input bit b);
      wreg(n, OFF_ENABLE, {15'b0, b});
      m_en[n] = b;
   endtask

   task automatic check_stat(input int n, input string req);
      logic [15:0] v;
      rreg(n, OFF_STATUS, v);
      chk(v == {8'h00, m_stat[n]}, req, v, {8'h00, m_stat[n]});
      m_stat[n] = 8'h00;
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [15:0] v;
      int unsigned seed_init;
      seed_init = $urandom(32'd20240517);
      rst_n = 1'b0; live = '1; wr = '0; rd = '0; addr = '0; wdata = '0;
      for (int i = 0; i < N; i++) begin m_stat[i] = 8'h00; m_en[i] = 1'b0; end
      repeat (3) tick;
      rst_n = 1'b1;
      tick;

      // R9: reset state
      chk(irq == '0, "R9 irq after reset", irq, 0);
      peek(0, OFF_ENABLE, v); chk(v == 16'h0, "R9 enable after reset", v, 0);
      peek(5, OFF_STATUS, v); chk(v == 16'h0, "R9 status after reset", v, 0);

      // R1: own index and live list
      live = 8'b1011_0111;
      for (int i = 0; i < N; i++) begin
         peek(i, OFF_SELF, v); chk(v == 16'(i), "R1 own index", v, i);
      end
      peek(3, OFF_LIVE, v); chk(v == 16'h00B7, "R1 live list", v, 16'h00B7);
      live = '1;

      // R3: enable reads back
      for (int i = 0; i < N; i++) set_en(i, 1'b1);
      peek(4, OFF_ENABLE, v); chk(v == 16'h1, "R3 enable readback", v, 1);

      // R2: point to point and self ring
      ring(2, 8'd6, 8'hA5);
      chk(irq == exp_irq(), "R2 irq after ring", irq, exp_irq());
      check_stat(6, "R2 point to point status");
      check_stat(2, "R2 sender status untouched");
      ring(3, 8'd3, 8'h3C);
      check_stat(3, "R2 self ring");

      // R4: second read sees zero
      check_stat(3, "R4 read cleared");

      // R4: delivery and clearing read at the same edge
      wr[2] = 1'b1; addr[2*4 +: 4] = OFF_BELL; wdata[2*16 +: 16] = {8'd6, 8'h77};
      tick;
      wr[2] = 1'b0;
      rreg(6, OFF_STATUS, v);
      chk(v == 16'h0, "R4 read before delivery", v, 0);
      peek(6, OFF_STATUS, v);
      chk(v == 16'h0077, "R4 delivery beats clear", v, 16'h0077);
      m_stat[6] = 8'h77;
      check_stat(6, "R4 collided message readable");

      // R3: disabled node keeps status but no irq
      set_en(1, 1'b0);
      ring(0, 8'd1, 8'h42);
      chk(irq[1] == 1'b0, "R3 masked irq low", irq[1], 0);
      set_en(1, 1'b1);
      chk(irq[1] == 1'b1, "R3 irq on enable", irq[1], 1);
      check_stat(1, "R3 masked status held");
      chk(irq[1] == 1'b0, "R3 irq drops after clear", irq[1], 0);

      // R5: broadcast to live nodes except sender
      live = 8'b1101_1111;
      ring(4, 8'hFF, 8'h9E);
      chk(irq == exp_irq(), "R5 broadcast irq vector", irq, exp_irq());
      for (int i = 0; i < N; i++) check_stat(i, "R5 broadcast status");

      // R6: dropped destinations
      ring(0, 8'd5, 8'h5A);
      ring(0, 8'd9, 8'h5B);
      ring(7, 8'd200, 8'h5C);
      chk(irq == '0, "R6 no irq after drops", irq, 0);
      for (int i = 0; i < N; i++) check_stat(i, "R6 dropped status");
      live = '1;

      // R7: contention at one destination
      wr[1] = 1'b1; addr[1*4 +: 4] = OFF_BELL; wdata[1*16 +: 16] = {8'd5, 8'h11};
      wr[3] = 1'b1; addr[3*4 +: 4] = OFF_BELL; wdata[3*16 +: 16] = {8'd5, 8'h33};
      tick;
      wr = '0;
      tick;
      peek(5, OFF_STATUS, v); chk(v == 16'h0011, "R7 lowest sender first", v, 16'h0011);
      tick;
      peek(5, OFF_STATUS, v); chk(v == 16'h0033, "R7 later sender overwrites", v, 16'h0033);
      m_stat[5] = 8'h33;
      check_stat(5, "R7 final status");

      // R8: writes to read-only and status offsets
      ring(0, 8'd2, 8'hC3);
      wreg(2, OFF_STATUS, 16'h00FF);
      wreg(2, OFF_SELF, 16'hFFFF);
      wreg(2, OFF_LIVE, 16'h0000);
      peek(2, OFF_SELF, v); chk(v == 16'h2, "R8 own index unchanged", v, 2);
      peek(2, OFF_LIVE, v); chk(v == 16'h00FF, "R8 live list unchanged", v, 16'h00FF);
      check_stat(2, "R8 status write ignored");

      // Random mix
      for (int it = 0; it < 400; it++) begin
         int s, n;
         logic [7:0] dest;
         logic [7:0] val;
         int pick;
         live = 8'($urandom) | 8'($urandom);
         if ($urandom_range(0, 3) == 0) set_en($urandom_range(0, N-1), 1'($urandom));
         s = $urandom_range(0, N-1);
         pick = $urandom_range(0, 9);
         if (pick < 7) dest = 8'($urandom_range(0, N-1));
         else if (pick < 9) dest = 8'hFF;
         else dest = 8'($urandom_range(N, 254));
         val = 8'($urandom);
         ring(s, dest, val);
         chk(irq == exp_irq(), "R3 random irq vector", irq, exp_irq());
         n = (dest < N && $urandom_range(0, 1) == 0) ? int'(dest) : $urandom_range(0, N-1);
         check_stat(n, "R2 R5 R6 random status");
      end

      summary();
   end
endmodule